// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Generator

This block keeps a running cyclic redundancy check over a byte stream. Each byte offered with a valid strobe is folded into the running value in one clock. The message may be any number of bytes long. Three generator polynomials are available: one 8-bit and two 16-bit. The register can shift toward the most significant end, for links that send the MSB first, or toward the least significant end with the bit-reversed polynomial, for links that send the LSB first.

Software sets the block up through a configuration write strobe. One write carries the polynomial select, the bit order and a clear request. The result can be read on `crc_out` in any cycle, and reading it does not change the running computation.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset `crc_out` is zero, the selection is the 8-bit polynomial, and the shift direction is MSB-first.
- R2: On a configuration write, `cfg_poly_sel` is stored as follows. Value 0 selects x^8+x^2+x+1 (0x07). Value 1 selects x^16+x^15+x^2+1 (0x8005). Value 2 selects x^16+x^12+x^5+1 (0x1021). Value 3 leaves the stored selection unchanged.
- R3: With `cfg_lsb_first`=0, the byte is XORed into the top of the register, which then shifts left eight times. Over the ASCII bytes "123456789" from zero, this gives 0x31C3 for selection 2 and 0x00F4 for selection 0.
- R4: With `cfg_lsb_first`=1, the byte is XORed into the bottom of the register, which then shifts right eight times using the bit-reversed polynomial. Over "123456789" with selection 1, this gives 0xBB3D.
- R5: A byte presented with `din_valid` high at one rising edge is reflected in `crc_out` after that edge. Back-to-back bytes are accepted every cycle.
- R6: A configuration write with `cfg_clear`=1 sets `crc_out` to zero at the next edge.
- R7: A configuration write that changes the stored polynomial selection also zeroes `crc_out`. A write of the same selection with `cfg_clear`=0 keeps the value.
- R8: While the 8-bit polynomial is selected, `crc_out[15:8]` reads as zero.
- R9: In a cycle with neither `din_valid` nor `cfg_we` high, `crc_out` keeps its value.
- R10: A byte presented in the same cycle as a configuration write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_poly_sel | input | 2 | Polynomial select written on `cfg_we` |
| cfg_lsb_first | input | 1 | Bit order written on `cfg_we` (1 = LSB-first) |
| cfg_clear | input | 1 | Clear request written on `cfg_we` |
| din_valid | input | 1 | Data byte strobe |
| din | input | 8 | Data byte |
| crc_out | output | 16 | Running CRC value |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. This holds for a byte update, a clear, a clear caused by a selection change, and a dropped byte. The bench's bit-serial model takes in the same inputs at that same edge. The model and `crc_out` are compared at every falling edge, so each comparison sees the state from the edge half a period before. The known check values for the "123456789" string are read at the falling edge after the last byte.

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter logic [15:0] POLY_A = 16'h0007,
  parameter logic [15:0] POLY_B = 16'h8005,
  parameter logic [15:0] POLY_C = 16'h1021,
  parameter int          BYTE_W = 8,
  parameter int          CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_poly_sel,
  input  logic              cfg_lsb_first,
  input  logic              cfg_clear,
  input  logic              din_valid,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int NARROW_W = 8;
  localparam logic [CRC_W-1:0] NARROW_MASK = CRC_W'((1 << NARROW_W) - 1);

  function automatic logic [CRC_W-1:0] flip(input logic [CRC_W-1:0] p, input int w);
    logic [CRC_W-1:0] q;
    q = '0;
    for (int i = 0; i < CRC_W; i++)
      if (i < w) q[w-1-i] = p[i];
    return q;
  endfunction

  localparam logic [CRC_W-1:0] RPOLY_A = flip(POLY_A, NARROW_W);
  localparam logic [CRC_W-1:0] RPOLY_B = flip(POLY_B, CRC_W);
  localparam logic [CRC_W-1:0] RPOLY_C = flip(POLY_C, CRC_W);

  logic [1:0]       sel_q;
  logic             lsb_q;
  logic [CRC_W-1:0] crc_q, crc_nxt, poly, rpoly;
  logic             sel_ok, sel_change;

  assign poly  = (sel_q == 2'd0) ? POLY_A  : (sel_q == 2'd1) ? POLY_B  : POLY_C;
  assign rpoly = (sel_q == 2'd0) ? RPOLY_A : (sel_q == 2'd1) ? RPOLY_B : RPOLY_C;
  assign sel_ok     = (cfg_poly_sel != 2'd3);
  assign sel_change = sel_ok && (cfg_poly_sel != sel_q);

  always_comb begin
    crc_nxt = crc_q;
    if (lsb_q) begin
      crc_nxt = crc_q ^ CRC_W'(din);
      for (int b = 0; b < BYTE_W; b++)
        crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ rpoly) : (crc_nxt >> 1);
    end else if (sel_q == 2'd0) begin
      crc_nxt = (crc_q ^ CRC_W'(din)) & NARROW_MASK;
      for (int b = 0; b < BYTE_W; b++)
        crc_nxt = crc_nxt[NARROW_W-1] ? (((crc_nxt << 1) & NARROW_MASK) ^ poly)
                                      : ((crc_nxt << 1) & NARROW_MASK);
    end else begin
      crc_nxt = crc_q ^ {din, {(CRC_W-BYTE_W){1'b0}}};
      for (int b = 0; b < BYTE_W; b++)
        crc_nxt = crc_nxt[CRC_W-1] ? ((crc_nxt << 1) ^ poly) : (crc_nxt << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'd0;
      lsb_q <= 1'b0;
      crc_q <= '0;
    end else if (cfg_we) begin
      if (sel_ok) sel_q <= cfg_poly_sel;
      lsb_q <= cfg_lsb_first;
      if (cfg_clear || sel_change) crc_q <= '0;
    end else if (din_valid) begin
      crc_q <= crc_nxt;
    end
  end

  assign crc_out = crc_q;

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'd0) |-> (crc_out[CRC_W-1:NARROW_W] == '0)); // R8
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_clear) |=> (crc_out == '0)); // R6
  AST_SEL_CHANGE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel_change) |=> (crc_out == '0)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !din_valid) |=> $stable(crc_out)); // R9
  AST_SEL_RESERVED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sel_ok) |=> $stable(sel_q)); // R2
  AST_SAME_SEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_clear && !sel_change) |=> $stable(crc_out)); // R10
endmodule

// File: tb/test_crc_byte_engine.sv
module test_crc_byte_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_poly_sel = 0;
  logic        cfg_lsb_first = 0;
  logic        cfg_clear = 0;
  logic        din_valid = 0;
  logic [7:0]  din = 0;
  logic [15:0] crc_out;

  int    n_run = 0, n_fail = 0;
  bit    done = 0, live = 0;
  string phase = "R1";

  int    m_crc = 0, m_sel = 0, m_lsb = 0;

  crc_byte_engine i_crc_byte_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly_sel(cfg_poly_sel),
    .cfg_lsb_first(cfg_lsb_first), .cfg_clear(cfg_clear),
    .din_valid(din_valid), .din(din), .crc_out(crc_out));

  always #2 clk = ~clk;

  function automatic int gen_poly(int sel);
    if (sel == 0) return 'h07;
    if (sel == 1) return 'h8005;
    return 'h1021;
  endfunction

  function automatic int ref_step(int c, int d, int sel, int lsb);
    int w = (sel == 0) ? 8 : 16;
    int p = gen_poly(sel);
    int mask = (1 << w) - 1;
    int rp = 0;
    for (int i = 0; i < w; i++) if ((p >> i) & 1) rp |= 1 << (w - 1 - i);
    for (int k = 0; k < 8; k++) begin
      int bitv = lsb ? ((d >> k) & 1) : ((d >> (7 - k)) & 1);
      int fb;
      if (lsb) begin
        fb = (c & 1) ^ bitv;
        c = c >> 1;
        if (fb) c = c ^ rp;
      end else begin
        fb = ((c >> (w - 1)) & 1) ^ bitv;
        c = (c << 1) & mask;
        if (fb) c = c ^ p;
      end
    end
    return c & mask;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crc = 0; m_sel = 0; m_lsb = 0;
    end else if (cfg_we) begin
      if (cfg_clear || (cfg_poly_sel != 3 && int'(cfg_poly_sel) != m_sel)) m_crc = 0;
      if (cfg_poly_sel != 3) m_sel = cfg_poly_sel;
      m_lsb = cfg_lsb_first;
    end else if (din_valid) begin
      m_crc = ref_step(m_crc, din, m_sel, m_lsb);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: crc_out=%04h expected %04h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (live && rst_n && !done) check(crc_out == 16'(m_crc), phase, crc_out, m_crc);

  task automatic step(bit we, int sel, bit lsb, bit clr, bit v, int d);
    cfg_we = we; cfg_poly_sel = 2'(sel); cfg_lsb_first = lsb; cfg_clear = clr;
    din_valid = v; din = 8'(d);
    @(negedge clk);
    cfg_we = 0; cfg_clear = 0; din_valid = 0;
  endtask

  task automatic send_digits();
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, "1" + i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: crc_out=%04h expected run end", crc_out);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(crc_out == 0, "R1 reset value", crc_out, 0);
    live = 1;

    phase = "R3 msb sel2";
    step(1, 2, 0, 1, 0, 0);
    send_digits();
    check(crc_out == 16'h31C3, "R3 check value sel2", crc_out, 'h31C3);

    phase = "R4 lsb sel1";
    step(1, 1, 1, 0, 0, 0);
    send_digits();
    check(crc_out == 16'hBB3D, "R4 check value sel1", crc_out, 'hBB3D);

    phase = "R2 R8 narrow";
    step(1, 0, 0, 0, 0, 0);
    send_digits();
    check(crc_out == 16'h00F4, "R2 R8 check value sel0", crc_out, 'hF4);

    phase = "R2 reserved select";
    step(1, 3, 0, 0, 0, 0);
    check(crc_out == 16'h00F4, "R2 reserved keeps value", crc_out, 'hF4);
    step(0, 0, 0, 0, 1, 'hA5);

    phase = "R7 same select keeps";
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 'h3C);
    step(1, 1, 1, 0, 0, 0);
    check(crc_out == 0, "R7 select change clears", crc_out, 0);

    phase = "R5 back to back";
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, i * 13);

    phase = "R10 byte during config";
    step(1, 1, 1, 0, 1, 'hFF);

    phase = "R9 idle";
    repeat (5) step(0, 0, 0, 0, 0, 'h77);

    phase = "R6 clear";
    step(1, 1, 0, 1, 0, 0);
    check(crc_out == 0, "R6 clear", crc_out, 0);

    phase = "R5 random mix";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) step(1, $urandom_range(0, 3), $urandom_range(0, 1), r < 2, $urandom_range(0, 1), $urandom_range(0, 255));
      else if (r < 80) step(0, 0, 0, 0, 1, $urandom_range(0, 255));
      else step(0, 0, 0, 0, 0, $urandom_range(0, 255));
    end
    finish_run();
  end
endmodule